// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block sits between one bus master and memory and turns each 32-bit virtual address into a physical address. A virtual address is cut into a 10-bit directory index (bits 31..22), a 10-bit table index (bits 21..12) and a 12-bit page offset (bits 11..0). The walker reads one 4-byte directory entry, located from a programmable base register, and then one 4-byte leaf entry through a read port with variable latency. It checks the presence bits at both levels and the read or write permission in the leaf entry. It then returns either the translated address or a fault code on a response port with a ready/valid handshake.

Only one translation is in flight at a time. A fault latches the faulting address, the fault type and the access direction into status outputs, and raises a level interrupt. The walker then stalls and refuses requests until software pulses the clear input. When translation is disabled, each request completes with the physical address equal to the virtual address and makes no memory reads.

The controller has seven states, and each transition is listed here:

- **IDLE**: on an accepted request it goes to DIR_REQ if translation is enabled, or to RESPOND if it is not.
- **DIR_REQ**: when the memory read is accepted it goes to DIR_WAIT.
- **DIR_WAIT**: when the entry arrives it goes to PTE_REQ if the entry is present, or to RESPOND with a fault if it is not.
- **PTE_REQ**: when the memory read is accepted it goes to PTE_WAIT.
- **PTE_WAIT**: when the entry arrives it goes to RESPOND.
- **RESPOND**: when the response is accepted it goes to STALLED after a fault, or to IDLE otherwise.
- **STALLED**: it goes back to IDLE once the latched fault has been cleared.

Top module: `pgw_translator`

## Requirements
- R1: After reset, req_ready is 1, while rsp_valid, mem_rd_valid and fault_irq are all 0.
- R2: With xlate_en low, a request completes with rsp_pa equal to the request address and rsp_fault 0. No memory read is issued.
- R3: The first memory read address is {base[31:12], 12'h000} + 4 * va[31:22]. Base bits 11..0 written through base_wdata have no effect.
- R4: The second memory read address is {dir_entry[31:12], 12'h000} + 4 * va[21:12].
- R5: On success, rsp_pa = {leaf_entry[31:12], va[11:0]}. Entry bits 11..3 do not affect the result.
- R6: A directory entry with bit 0 clear ends the walk after one read, with rsp_fault 1 and fault code 1.
- R7: A leaf entry with bit 0 clear gives fault code 2.
- R8: A present leaf gives fault code 3 when a read meets bit 1 clear, or when a write meets bit 2 clear. Fault code 0 means no fault.
- R9: On a fault, fault_irq rises and holds. fault_va, fault_code and fault_write hold the faulting request, and req_ready stays 0. One cycle with fault_clr high drops fault_irq, and req_ready returns one cycle later.
- R10: req_ready is 0 from an accepted request until its response is accepted. While rsp_ready is low, rsp_valid, rsp_pa and rsp_fault_code hold steady.
- R11: A memory read request holds its valid and address until mem_rd_ready accepts it, whatever the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable; when low, addresses pass through unchanged |
| base_we | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | Directory base; bits 31..12 are stored |
| fault_clr | input | 1 | Pulse that clears the latched fault |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Master accepts the result |
| rsp_pa | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Result is a fault |
| rsp_fault_code | output | 2 | 0 none, 1 directory absent, 2 page absent, 3 permission |
| fault_irq | output | 1 | Level fault interrupt |
| fault_va | output | 32 | Latched faulting virtual address |
| fault_code | output | 2 | Latched fault code |
| fault_write | output | 1 | Latched access direction of the fault |

## Verification
Some properties are checked by the embedded assertions on every cycle. These are the one-walk-at-a-time rule, the holding of the response and of memory requests under back-pressure, and the page offset carried into every successful result. They also cover the refusal of requests while a fault is pending, and the holding and clearing of the interrupt. Other behaviour can only be shown by the bench scenarios, because it depends on table contents the bench chose:

- the exact fetch addresses at both levels;
- the translated frame;
- the choice among the three fault codes;
- the absence of reads in pass-through mode;
- the ignored entry and base bits.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_PTE_REQ,
        ST_PTE_WAIT,
        ST_RESPOND,
        ST_STALLED
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_DIR_ABSENT  = 2'd1,
        FLT_PAGE_ABSENT = 2'd2,
        FLT_PERM        = 2'd3
    } fault_code_e;

    localparam int ENT_PRESENT = 0;
    localparam int ENT_RD_OK   = 1;
    localparam int ENT_WR_OK   = 2;

endpackage

// File: rtl/pgw_addr.sv
module pgw_addr
    import pgw_pkg::*;
#(
    parameter int L1_W      = 10,
    parameter int L2_W      = 10,
    parameter int OFF_W     = 12,
    parameter int IDX_SHIFT = 2,
    parameter int AW        = L1_W + L2_W + OFF_W
) (
    input  logic [AW-1:OFF_W] dir_base,
    input  logic [AW-1:0]     va_new,
    input  logic [AW-1:0]     va_held,
    input  logic [AW-1:0]     entry,
    input  logic              want_write,
    output logic [AW-1:0]     dir_addr,
    output logic [AW-1:0]     pte_addr,
    output logic [AW-1:0]     leaf_pa,
    output logic              next_present,
    output fault_code_e       leaf_code
);
    localparam int L2_LSB = OFF_W;
    localparam int L1_LSB = OFF_W + L2_W;

    logic [L1_W-1:0] idx1;
    logic [L2_W-1:0] idx2;
    logic            perm_ok;
    logic            unused_bits;

    assign idx1 = va_new[L1_LSB +: L1_W];
    assign idx2 = va_held[L2_LSB +: L2_W];

    assign dir_addr = {dir_base, {OFF_W{1'b0}}} + (AW'(idx1) << IDX_SHIFT);
    assign pte_addr = {entry[AW-1:OFF_W], {OFF_W{1'b0}}} + (AW'(idx2) << IDX_SHIFT);
    assign leaf_pa  = {entry[AW-1:OFF_W], va_held[OFF_W-1:0]};

    assign next_present = entry[ENT_PRESENT];
    assign perm_ok      = want_write ? entry[ENT_WR_OK] : entry[ENT_RD_OK];

    always_comb begin
        if (!entry[ENT_PRESENT]) begin
            leaf_code = FLT_PAGE_ABSENT;
        end else if (!perm_ok) begin
            leaf_code = FLT_PERM;
        end else begin
            leaf_code = FLT_NONE;
        end
    end

    assign unused_bits = ^{entry[OFF_W-1:ENT_WR_OK+1], va_new[L1_LSB-1:0],
                           va_held[AW-1:L1_LSB]};

endmodule

// File: rtl/pgw_fault_regs.sv
module pgw_fault_regs
    import pgw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [AW-1:0]     base_wdata,
    output logic [AW-1:OFF_W] base_q,
    input  logic              fault_set,
    input  logic [AW-1:0]     set_va,
    input  fault_code_e       set_code,
    input  logic              set_write,
    input  logic              fault_clr,
    output logic              irq,
    output logic [AW-1:0]     fault_va,
    output fault_code_e       fault_code,
    output logic              fault_write
);
    logic unused_bits;

    assign unused_bits = ^base_wdata[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_we) begin
            base_q <= base_wdata[AW-1:OFF_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq         <= 1'b0;
            fault_va    <= '0;
            fault_code  <= FLT_NONE;
            fault_write <= 1'b0;
        end else if (fault_set) begin
            irq         <= 1'b1;
            fault_va    <= set_va;
            fault_code  <= set_code;
            fault_write <= set_write;
        end else if (fault_clr) begin
            irq <= 1'b0;
        end
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !fault_clr |=> irq); // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr && !fault_set |=> !irq); // R9

endmodule

// File: rtl/pgw_walk_fsm.sv
module pgw_walk_fsm
    import pgw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xlate_en,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_va,
    input  logic          req_write,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic          mem_rsp_ready_unused_tie,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_pa,
    output fault_code_e   rsp_code,
    output logic [AW-1:0] va_q,
    output logic          wr_q,
    input  logic [AW-1:0] dir_addr,
    input  logic [AW-1:0] pte_addr,
    input  logic [AW-1:0] leaf_pa,
    input  logic          next_present,
    input  fault_code_e   leaf_code,
    input  logic          fault_pending,
    output logic          fault_set,
    output fault_code_e   set_code
);
    walk_state_e   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] pa_q;
    fault_code_e   code_q;
    logic          unused_tie;

    assign unused_tie = mem_rsp_ready_unused_tie;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = xlate_en ? ST_DIR_REQ : ST_RESPOND;
                end
            end
            ST_DIR_REQ: begin
                if (mem_rd_ready) state_d = ST_DIR_WAIT;
            end
            ST_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = next_present ? ST_PTE_REQ : ST_RESPOND;
                end
            end
            ST_PTE_REQ: begin
                if (mem_rd_ready) state_d = ST_PTE_WAIT;
            end
            ST_PTE_WAIT: begin
                if (mem_rsp_valid) state_d = ST_RESPOND;
            end
            ST_RESPOND: begin
                if (rsp_ready) begin
                    state_d = (code_q != FLT_NONE) ? ST_STALLED : ST_IDLE;
                end
            end
            ST_STALLED: begin
                if (!fault_pending) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // walk data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            pa_q   <= '0;
            code_q <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        wr_q   <= req_write;
                        addr_q <= dir_addr;
                        pa_q   <= req_va;
                        code_q <= FLT_NONE;
                    end
                end
                ST_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        addr_q <= pte_addr;
                        if (!next_present) begin
                            code_q <= FLT_DIR_ABSENT;
                            pa_q   <= '0;
                        end
                    end
                end
                ST_PTE_WAIT: begin
                    if (mem_rsp_valid) begin
                        code_q <= leaf_code;
                        pa_q   <= (leaf_code == FLT_NONE) ? leaf_pa : '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        rsp_valid    = 1'b0;
        fault_set    = 1'b0;
        set_code     = FLT_NONE;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_DIR_REQ:  mem_rd_valid = 1'b1;
            ST_PTE_REQ:  mem_rd_valid = 1'b1;
            ST_DIR_WAIT: begin
                if (mem_rsp_valid && !next_present) begin
                    fault_set = 1'b1;
                    set_code  = FLT_DIR_ABSENT;
                end
            end
            ST_PTE_WAIT: begin
                if (mem_rsp_valid && leaf_code != FLT_NONE) begin
                    fault_set = 1'b1;
                    set_code  = leaf_code;
                end
            end
            ST_RESPOND:  rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign mem_rd_addr = addr_q;
    assign rsp_pa      = pa_q;
    assign rsp_code    = code_q;

    AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R10
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_code)); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R11
    AST_STALL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pending |-> !req_ready); // R9
    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_code == FLT_NONE |-> rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]); // R5

endmodule

// File: rtl/pgw_translator.sv
module pgw_translator
    import pgw_pkg::*;
#(
    parameter int L1_W      = 10,
    parameter int L2_W      = 10,
    parameter int OFF_W     = 12,
    parameter int IDX_SHIFT = 2,
    parameter int AW        = L1_W + L2_W + OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xlate_en,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          fault_clr,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_va,
    input  logic          req_write,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_pa,
    output logic          rsp_fault,
    output logic [1:0]    rsp_fault_code,
    output logic          fault_irq,
    output logic [AW-1:0] fault_va,
    output logic [1:0]    fault_code,
    output logic          fault_write
);
    logic [AW-1:OFF_W] base_q;
    logic [AW-1:0]     va_q, dir_addr, pte_addr, leaf_pa;
    logic              wr_q, next_present, fault_set;
    fault_code_e       leaf_code, set_code, rsp_code, flt_code;

    pgw_addr #(
        .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W), .IDX_SHIFT(IDX_SHIFT), .AW(AW)
    ) u_addr (
        .dir_base     (base_q),
        .va_new       (req_va),
        .va_held      (va_q),
        .entry        (mem_rsp_data),
        .want_write   (wr_q),
        .dir_addr     (dir_addr),
        .pte_addr     (pte_addr),
        .leaf_pa      (leaf_pa),
        .next_present (next_present),
        .leaf_code    (leaf_code)
    );

    pgw_walk_fsm #(.AW(AW), .OFF_W(OFF_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .xlate_en      (xlate_en),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_write     (req_write),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_ready_unused_tie (1'b0),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_pa        (rsp_pa),
        .rsp_code      (rsp_code),
        .va_q          (va_q),
        .wr_q          (wr_q),
        .dir_addr      (dir_addr),
        .pte_addr      (pte_addr),
        .leaf_pa       (leaf_pa),
        .next_present  (next_present),
        .leaf_code     (leaf_code),
        .fault_pending (fault_irq),
        .fault_set     (fault_set),
        .set_code      (set_code)
    );

    pgw_fault_regs #(.AW(AW), .OFF_W(OFF_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_we     (base_we),
        .base_wdata  (base_wdata),
        .base_q      (base_q),
        .fault_set   (fault_set),
        .set_va      (va_q),
        .set_code    (set_code),
        .set_write   (wr_q),
        .fault_clr   (fault_clr),
        .irq         (fault_irq),
        .fault_va    (fault_va),
        .fault_code  (flt_code),
        .fault_write (fault_write)
    );

    assign rsp_fault      = (rsp_code != FLT_NONE);
    assign rsp_fault_code = rsp_code;
    assign fault_code     = flt_code;

endmodule

// File: tb/pgw_translator_test.sv
module pgw_translator_test;

    typedef struct packed {
        logic        en;
        logic        wr;
        logic [31:0] va;
        logic [31:0] dent;
        logic [31:0] pent;
        logic [3:0]  lat;
        logic [1:0]  hold;
        logic [1:0]  code;
    } vec_t;

    localparam int NV = 8;
    localparam logic [31:0] BASE_WR = 32'h0004_0ABC;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h1234_5678, 32'h0,          32'h0,          4'd0, 2'd1, 2'd0}, // R2
        '{1'b1, 1'b0, 32'h0040_1ABC, 32'h0010_0001, 32'hABCD_E003, 4'd0, 2'd0, 2'd0}, // R3 R4 R5
        '{1'b1, 1'b1, 32'hFFC0_0FFF, 32'h2222_2FF9, 32'h1357_9FF5, 4'd3, 2'd2, 2'd0}, // R5 R8
        '{1'b1, 1'b0, 32'h8000_3004, 32'h0000_0FFE, 32'h0,          4'd2, 2'd0, 2'd1}, // R6
        '{1'b1, 1'b0, 32'h0000_1000, 32'h0030_0001, 32'h5555_5006, 4'd1, 2'd1, 2'd2}, // R7
        '{1'b1, 1'b0, 32'h0123_4567, 32'h0030_0001, 32'h7777_7005, 4'd5, 2'd0, 2'd3}, // R8
        '{1'b1, 1'b1, 32'h0123_4567, 32'h0030_0001, 32'h7777_7003, 4'd0, 2'd3, 2'd3}, // R8
        '{1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0,          32'h0,          4'd0, 2'd0, 2'd0}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0, base_we = 1'b0, fault_clr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready;
    logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
    logic [31:0] mem_rd_addr, mem_rsp_data;
    logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_fault_code, fault_code;
    logic        fault_irq, fault_write;
    logic [31:0] fault_va;

    int checks = 0, failures = 0;
    int fetch_n = 0;
    logic [31:0] fetch_addr [2];
    logic [31:0] cur_dent = '0, cur_pent = '0;
    int cur_lat = 0;

    always #2.5 clk = ~clk;

    pgw_translator uut (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .base_we(base_we),
        .base_wdata(base_wdata), .fault_clr(fault_clr), .req_valid(req_valid),
        .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_fault_code(rsp_fault_code),
        .fault_irq(fault_irq), .fault_va(fault_va), .fault_code(fault_code),
        .fault_write(fault_write)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model with variable latency on both request and data
    initial begin
        mem_rd_ready  = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                for (int i = 0; i < cur_lat; i++) @(negedge clk);
                if (fetch_n < 2) fetch_addr[fetch_n] = mem_rd_addr;
                mem_rd_ready = 1'b1;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                for (int i = 0; i < cur_lat; i++) @(negedge clk);
                mem_rsp_data  = (fetch_n == 0) ? cur_dent : cur_pent;
                fetch_n++;
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic run_vec(input vec_t v);
        logic [31:0] exp_pa, exp_a0, exp_a1, got_pa;
        int exp_fetch;
        exp_a0    = {BASE_WR[31:12], 12'h000} + {20'h0, v.va[31:22], 2'b00};
        exp_a1    = {v.dent[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00};
        exp_pa    = !v.en ? v.va : (v.code == 2'd0 ? {v.pent[31:12], v.va[11:0]} : 32'h0);
        exp_fetch = !v.en ? 0 : (v.code == 2'd1 ? 1 : 2);
        cur_dent = v.dent; cur_pent = v.pent; cur_lat = int'(v.lat);
        fetch_n = 0;
        @(negedge clk);
        xlate_en = v.en; req_va = v.va; req_write = v.wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10 ready low during walk", {31'h0, req_ready}, 32'h0);
        while (!rsp_valid) @(negedge clk);
        got_pa = rsp_pa;
        for (int h = 0; h < int'(v.hold); h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_pa == got_pa, "R10 response held", rsp_pa, got_pa);
        end
        chk(rsp_pa == exp_pa, "R5/R2 physical address", rsp_pa, exp_pa);
        chk(rsp_fault_code == v.code, "R6/R7/R8 fault code", {30'h0, rsp_fault_code}, {30'h0, v.code});
        chk(rsp_fault == (v.code != 0), "R6 fault flag", {31'h0, rsp_fault}, {31'h0, v.code != 0});
        chk(fetch_n == exp_fetch, "R2/R6 fetch count", 32'(fetch_n), 32'(exp_fetch));
        if (exp_fetch >= 1) chk(fetch_addr[0] == exp_a0, "R3 directory address", fetch_addr[0], exp_a0);
        if (exp_fetch >= 2) chk(fetch_addr[1] == exp_a1, "R4 leaf address", fetch_addr[1], exp_a1);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        if (v.code != 2'd0) begin
            chk(fault_irq, "R9 irq raised", {31'h0, fault_irq}, 32'h1);
            chk(fault_va == v.va, "R9 fault address", fault_va, v.va);
            chk(fault_code == v.code, "R9 fault code latched", {30'h0, fault_code}, {30'h0, v.code});
            chk(fault_write == v.wr, "R9 fault direction", {31'h0, fault_write}, {31'h0, v.wr});
            req_valid = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(!req_ready && !rsp_valid, "R9 stalled refuses", {31'h0, req_ready}, 32'h0);
            end
            req_valid = 1'b0;
            fault_clr = 1'b1;
            @(negedge clk);
            fault_clr = 1'b0;
            chk(!fault_irq, "R9 irq cleared", {31'h0, fault_irq}, 32'h0);
            @(negedge clk);
            chk(req_ready, "R9 ready after clear", {31'h0, req_ready}, 32'h1);
        end else begin
            chk(!fault_irq, "R9 no irq on success", {31'h0, fault_irq}, 32'h0);
            chk(req_ready, "R10 ready after accept", {31'h0, req_ready}, 32'h1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 reset ready", {31'h0, req_ready}, 32'h1);
        chk(!rsp_valid && !mem_rd_valid, "R1 reset idle outputs", {31'h0, rsp_valid}, 32'h0);
        chk(!fault_irq, "R1 reset irq", {31'h0, fault_irq}, 32'h0);
        base_we = 1'b1; base_wdata = BASE_WR;
        @(negedge clk);
        base_we = 1'b0;
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        // R11: request held across a long acceptance delay
        cur_dent = 32'h0010_0001; cur_pent = 32'h0000_1003; cur_lat = 9; fetch_n = 0;
        @(negedge clk);
        xlate_en = 1'b1; req_va = 32'h0000_0000; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(mem_rd_valid && mem_rd_addr == 32'h0004_0000, "R11 held request",
            mem_rd_addr, 32'h0004_0000);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_pa == 32'h0000_1000 && !rsp_fault, "R11 slow walk result", rsp_pa, 32'h0000_1000);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule